// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real time clock. It takes a 32.768 kHz enable pulse, divides it down to one tick per second, and advances a set of packed BCD registers: seconds, minutes, hours, date of the month, month, weekday and a two-digit year. A carry out of one field moves the next field on the same clock edge. The date wraps at the correct month end, and February gets its 29th day in years divisible by four, which is correct for every year up to 2100.

The hours register can run in 24-hour form or in 12-hour form with a PM flag. A halt bit stored alongside the seconds stops all counting. A host loads any field through a parallel write port and sees every field at once on registered outputs. The oscillator, power switching and any serial access protocol are outside this block.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read seconds 0x00 with the halt bit clear, minutes 0x00, hours 0x00 in 24-hour form, date 0x01, month 0x01, weekday 0x01 and year 0x00. The prescaler starts from zero.
- R2: The seconds advance once for every PRESCALE clocks on which tick_en is high, with PRESCALE defaulting to 32768. Clocks with tick_en low do not count.
- R3: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: When hours bit 7 is 0 the hour counts 00 to 23 in BCD in bits 5:0, with bit 5 holding the tens digit 2. After 23 it wraps to 00 and carries into the date and weekday.
- R5: When hours bit 7 is 1 the hour runs 01 to 12 in bits 4:0 and bit 5 is the PM flag (1 means PM). Going from 11 to 12 toggles the PM flag. Going from 12 leads to 01. The date carry occurs only on the step from 11 PM to 12 AM.
- R6: After the last day of the month the date wraps to 01 and carries into the month. The last day is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all other months.
- R7: A year whose BCD value is divisible by 4, year 00 included, gives February 29 days. Any other year gives February 28 days.
- R8: The month counts 01 to 12 and wraps to 01 with a carry into the year. The year counts 00 to 99 and wraps to 00.
- R9: The weekday counts 1 to 7, wraps to 1, and advances on every date carry.
- R10: While seconds bit 7 (halt) is 1, no field changes and the prescaler holds its count. Writing a seconds value with bit 7 clear resumes counting.
- R11: A write with wr_en high loads wr_data into one field on the next edge. The field is chosen by wr_addr: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year. Address 7 changes nothing. Unused bits read back as 0: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and weekday bits 7:3.
- R12: Writing the seconds field clears the prescaler, so the next second comes a full PRESCALE enabled clocks after the write.
- R13: When a carry ripples from the seconds through to the year, every field involved takes its new value on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock enable pulse at the 32.768 kHz reference rate |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to load |
| sec_o | output | 8 | Halt bit 7 and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode bit 7, PM or tens bit 5, BCD hour |
| date_o | output | 8 | BCD date of month |
| month_o | output | 8 | BCD month |
| wday_o | output | 8 | Weekday 1 to 7 |
| year_o | output | 8 | BCD year |

## Verification
A wrong prescaler count shows up on sec_o one enabled pulse early or late, on the edge where the second should change. A wrong month length or leap decision stays hidden until a month boundary. Only then does date_o or month_o show the error, on the edge of the day carry. The bench therefore sets the calendar to month ends, to February in both leap and ordinary years, and to 11 and 12 o'clock in 12-hour form, and it compares all seven outputs after every step. That way a broken ripple shows on the same edge where it happens.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_WDAY  = 5;
  localparam int F_YEAR  = 6;

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Leap test on a BCD year: the value is a multiple of four.
  function automatic logic bcd_leap(input logic [7:0] y);
    logic r;
    if (y[4] == 1'b0) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic int field_width(input int i);
    int r;
    case (i)
      F_SEC, F_MIN: r = 7;
      F_DATE:       r = 6;
      F_MONTH:      r = 5;
      F_WDAY:       r = 3;
      default:      r = 8;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] field_bottom(input int i);
    logic [7:0] r;
    case (i)
      F_DATE, F_MONTH, F_WDAY: r = 8'h01;
      default:                 r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] field_top(input int i);
    logic [7:0] r;
    case (i)
      F_MONTH: r = 8'h12;
      F_WDAY:  r = 8'h07;
      F_YEAR:  r = 8'h99;
      default: r = 8'h59;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic halt,
  input  logic clear,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt;

  assign tick_o = tick_en && !halt && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)          cnt <= '0;
    else if (tick_en && !halt) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R2
    end
  endgenerate

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (halt && !clear) |=> $stable(cnt)); // R10

endmodule

// File: rtl/rtc_bcd_cell.sv
module rtc_bcd_cell #(
  parameter int         W      = 7,
  parameter logic [7:0] BOTTOM = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] top,
  output logic [7:0] q_o,
  output logic       carry
);
  import rtc_pkg::*;

  localparam logic [7:0] MASK = 8'((1 << W) - 1);

  logic [7:0] q;

  assign carry = inc && !load && (q == top);
  assign q_o   = q;

  always_ff @(posedge clk) begin
    if (rst)        q <= BOTTOM;
    else if (load)  q <= load_val & MASK;
    else if (inc)   q <= ((q == top) ? BOTTOM : bcd_inc(q)) & MASK;
  end

endmodule

// File: rtl/rtc_hour_cell.sv
module rtc_hour_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] q_o,
  output logic       day_carry
);
  import rtc_pkg::*;

  logic [7:0] q;
  logic [7:0] nxt;
  logic       wrap;
  logic [7:0] h12;
  logic [7:0] h24;
  logic [7:0] h12_inc;
  logic [7:0] h24_inc;

  assign h12     = {3'b000, q[4:0]};
  assign h24     = {2'b00, q[5:0]};
  assign h12_inc = bcd_inc(h12);
  assign h24_inc = bcd_inc(h24);

  always_comb begin
    wrap = 1'b0;
    if (q[7]) begin
      if (h12 == 8'h11) begin
        nxt  = {2'b10, ~q[5], 5'h12};
        wrap = q[5];
      end else if (h12 == 8'h12) begin
        nxt  = {2'b10, q[5], 5'h01};
      end else begin
        nxt  = {2'b10, q[5], h12_inc[4:0]};
      end
    end else begin
      if (h24 == 8'h23) begin
        nxt  = 8'h00;
        wrap = 1'b1;
      end else begin
        nxt  = {2'b00, h24_inc[5:0]};
      end
    end
  end

  assign day_carry = inc && !load && wrap;
  assign q_o       = q;

  always_ff @(posedge clk) begin
    if (rst)       q <= 8'h00;
    else if (load) q <= load_val & 8'hBF;
    else if (inc)  q <= nxt;
  end

  AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && q[7] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5]) && q[4:0] == 5'h12)); // R5

  AST_H24_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !q[7] && q[5:0] == 6'h23) |=> (q == 8'h00)); // R4

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  import rtc_pkg::*;

  logic                  sec_tick;
  logic                  halt_q;
  logic [NUM_FIELDS-1:0] sel;
  logic [NUM_FIELDS-1:0] inc;
  logic [NUM_FIELDS-1:0] carry;
  logic [7:0]            field_q [NUM_FIELDS];
  logic [7:0]            date_last;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) sel[i] = wr_en && (wr_addr == 3'(i));
  end

  always_ff @(posedge clk) begin
    if (rst)             halt_q <= 1'b0;
    else if (sel[F_SEC]) halt_q <= wr_data[7];
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .halt    (halt_q),
    .clear   (sel[F_SEC]),
    .tick_o  (sec_tick)
  );

  assign date_last = month_last_day(field_q[F_MONTH], bcd_leap(field_q[F_YEAR]));

  assign inc[F_SEC]   = sec_tick;
  assign inc[F_MIN]   = carry[F_SEC];
  assign inc[F_HOUR]  = carry[F_MIN];
  assign inc[F_DATE]  = carry[F_HOUR];
  assign inc[F_MONTH] = carry[F_DATE];
  assign inc[F_WDAY]  = carry[F_HOUR];
  assign inc[F_YEAR]  = carry[F_MONTH];

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      if (i == F_HOUR) begin : g_hour
        rtc_hour_cell u_hour (
          .clk       (clk),
          .rst       (rst),
          .inc       (inc[i]),
          .load      (sel[i]),
          .load_val  (wr_data),
          .q_o       (field_q[i]),
          .day_carry (carry[i])
        );
      end else begin : g_cell
        rtc_bcd_cell #(.W(field_width(i)), .BOTTOM(field_bottom(i))) u_cell (
          .clk      (clk),
          .rst      (rst),
          .inc      (inc[i]),
          .load     (sel[i]),
          .load_val (wr_data),
          .top      ((i == F_DATE) ? date_last : field_top(i)),
          .q_o      (field_q[i]),
          .carry    (carry[i])
        );
      end
    end
  endgenerate

  assign sec_o   = field_q[F_SEC] | {halt_q, 7'b0};
  assign min_o   = field_q[F_MIN];
  assign hour_o  = field_q[F_HOUR];
  assign date_o  = field_q[F_DATE];
  assign month_o = field_q[F_MONTH];
  assign wday_o  = field_q[F_WDAY];
  assign year_o  = field_q[F_YEAR];

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                            $stable(date_o) && $stable(month_o) && $stable(year_o))); // R10

  AST_MINUTE_RIPPLE: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59) |=>
      (sec_o == 8'h00 && min_o == 8'h00 && hour_o != $past(hour_o))); // R13

  AST_MONTH_END: assert property (@(posedge clk) disable iff (rst)
    (carry[F_DATE] && !wr_en) |=> (date_o == 8'h01 && month_o != $past(month_o))); // R6

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (carry[F_WDAY] && !wr_en) |=> (wday_o == 8'h01)); // R9

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (carry[F_YEAR] && !wr_en) |=> (year_o == 8'h00)); // R8

endmodule

// File: tb/test_rtc_bcd_core.sv
`timescale 1ns/1ps
module test_rtc_bcd_core;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;

  int checks = 0;
  int fails  = 0;
  int m_s = 0, m_mi = 0, m_h = 0, m_pm = 0, m_m12 = 0, m_d = 1, m_mo = 1;
  int m_wd = 1, m_y = 0, m_halt = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.PRESCALE(P)) i_rtc_bcd_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .wday_o(wday_o), .year_o(year_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_hour();
    logic [7:0] b;
    b = bcd(m_h);
    if (m_m12 != 0) return {1'b1, 1'b0, m_pm[0], b[4:0]};
    return {2'b00, b[5:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] s;
    s = bcd(m_s);
    chk(req, "sec",   sec_o,   {m_halt[0], s[6:0]});
    chk(req, "min",   min_o,   bcd(m_mi));
    chk(req, "hour",  hour_o,  exp_hour());
    chk(req, "date",  date_o,  bcd(m_d));
    chk(req, "month", month_o, bcd(m_mo));
    chk(req, "wday",  wday_o,  bcd(m_wd));
    chk(req, "year",  year_o,  bcd(m_y));
  endtask

  task automatic adv_second();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0;
    if (m_m12 != 0) begin
      if (m_h == 11) begin
        m_h = 12; m_pm ^= 1;
        if (m_pm != 0) return;
      end else begin
        m_h = (m_h == 12) ? 1 : m_h + 1;
        return;
      end
    end else begin
      m_h++;
      if (m_h < 24) return;
      m_h = 0;
    end
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_d++;
    if (m_d <= dim(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y = (m_y + 1) % 100;
  endtask

  task automatic pulse(input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      if (m_halt == 0) begin
        m_cnt++;
        if (m_cnt == P) begin m_cnt = 0; adv_second(); end
      end
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      0: begin m_halt = int'(d[7]); m_s = unbcd(d & 8'h7F); m_cnt = 0; end
      1: m_mi = unbcd(d & 8'h7F);
      2: begin
        m_m12 = int'(d[7]);
        if (d[7]) begin m_pm = int'(d[5]); m_h = unbcd(d & 8'h1F); end
        else begin m_pm = 0; m_h = unbcd(d & 8'h3F); end
      end
      3: m_d  = unbcd(d & 8'h3F);
      4: m_mo = unbcd(d & 8'h1F);
      5: m_wd = int'(d[2:0]);
      6: m_y  = unbcd(d);
      default: ;
    endcase
  endtask

  task automatic set_all(input int m12, input int pm, input int h, input int mi, input int s,
                         input int d, input int mo, input int wd, input int y);
    logic [7:0] hb;
    hb = bcd(h);
    wr(2, (m12 != 0) ? {1'b1, 1'b0, pm[0], hb[4:0]} : hb);
    wr(1, bcd(mi)); wr(3, bcd(d)); wr(4, bcd(mo)); wr(5, bcd(wd)); wr(6, bcd(y));
    wr(0, bcd(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2: P-1 pulses leave the second unchanged, with idle gaps in between
    pulse(P - 1, 1'b1);
    chk("R2", "sec before", sec_o, 8'h00);
    pulse(1, 1'b0);
    chk("R2", "sec after", sec_o, 8'h01);

    // R12: write of seconds restarts the prescaler
    pulse(2, 1'b0);
    wr(0, 8'h30);
    pulse(P - 1, 1'b0);
    chk("R12", "sec held", sec_o, 8'h30);
    pulse(1, 1'b0);
    chk("R12", "sec step", sec_o, 8'h31);

    // R13, R4, R8, R9: full ripple from 23:59:59 Dec 31 99
    set_all(0, 0, 23, 59, 59, 31, 12, 7, 99);
    pulse(P, 1'b0);
    check_all("R13");
    chk("R8", "year wrap", year_o, 8'h00);
    chk("R9", "wday wrap", wday_o, 8'h01);
    chk("R4", "hour wrap", hour_o, 8'h00);

    // R5: 12-hour transitions
    set_all(1, 0, 11, 59, 59, 10, 5, 3, 21);
    pulse(P, 1'b0);
    chk("R5", "11AM to 12PM", hour_o, 8'hB2);
    chk("R5", "no day carry", date_o, 8'h10);
    set_all(1, 1, 12, 59, 59, 10, 5, 3, 21);
    pulse(P, 1'b0);
    chk("R5", "12PM to 1PM", hour_o, 8'hA1);
    set_all(1, 1, 11, 59, 59, 10, 5, 3, 21);
    pulse(P, 1'b0);
    chk("R5", "11PM to 12AM", hour_o, 8'h92);
    chk("R5", "day carry", date_o, 8'h11);
    check_all("R5");

    // R6, R7: month ends
    set_all(0, 0, 23, 59, 59, 30, 4, 1, 22);
    pulse(P, 1'b0);
    chk("R6", "april end date", date_o, 8'h01);
    chk("R6", "april end month", month_o, 8'h05);
    set_all(0, 0, 23, 59, 59, 28, 2, 1, 24);
    pulse(P, 1'b0);
    chk("R7", "leap feb 29", date_o, 8'h29);
    set_all(0, 0, 23, 59, 59, 28, 2, 1, 0);
    pulse(P, 1'b0);
    chk("R7", "year 00 feb 29", date_o, 8'h29);
    set_all(0, 0, 23, 59, 59, 28, 2, 1, 23);
    pulse(P, 1'b0);
    chk("R7", "plain feb end", date_o, 8'h01);
    chk("R7", "plain feb month", month_o, 8'h03);
    set_all(0, 0, 23, 59, 59, 31, 1, 1, 23);
    pulse(P, 1'b0);
    check_all("R6");

    // R10: halt freezes, clearing halt resumes
    wr(0, 8'h80 | 8'h10);
    pulse(3 * P, 1'b1);
    check_all("R10");
    wr(0, 8'h10);
    pulse(P, 1'b0);
    chk("R10", "resume", sec_o, 8'h11);

    // R11: address 7 has no effect, unused bits read zero
    wr(7, 8'hFF);
    check_all("R11");
    wr(1, 8'h85); chk("R11", "min mask",   min_o,   8'h05);
    wr(2, 8'h45); chk("R11", "hour mask",  hour_o,  8'h05);
    wr(3, 8'hD5); chk("R11", "date mask",  date_o,  8'h15);
    wr(4, 8'hE9); chk("R11", "month mask", month_o, 8'h09);
    wr(5, 8'hFB); chk("R11", "wday mask",  wday_o,  8'h03);
    check_all("R11");

    // R3: random calendars biased toward carries
    for (int it = 0; it < 60; it++) begin
      int y, mo, d, m12, pm, h, mi, s;
      y   = $urandom_range(0, 99);
      mo  = $urandom_range(1, 12);
      d   = $urandom_range(0, 1) ? dim(mo, y) : $urandom_range(1, dim(mo, y));
      m12 = $urandom_range(0, 1);
      pm  = $urandom_range(0, 1);
      if (m12 != 0) h = $urandom_range(0, 1) ? (10 + $urandom_range(1, 2)) : $urandom_range(1, 12);
      else          h = $urandom_range(0, 1) ? 23 : $urandom_range(0, 23);
      mi  = $urandom_range(0, 1) ? 59 : $urandom_range(0, 59);
      s   = $urandom_range(0, 1) ? 59 : $urandom_range(0, 59);
      set_all(m12, pm, h, mi, s, d, mo, $urandom_range(1, 7), y);
      pulse(P * $urandom_range(1, 3), 1'b1);
      check_all("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule